// File: doc/BRIEF.md
# Frequency lock and loss-of-lock detector

This block decides whether a frequency-locked loop is running at its target rate. A fast oscillator clock is measured against a slower, independent reference clock. The reference side defines a comparison period of a programmable number of its own cycles. Over each period the oscillator side counts its own rising edges. That count crosses back to the reference domain through a toggle handshake. There the programmed target count is subtracted from it, which gives a signed count error.

While unlocked, the block declares lock only when the error falls inside a narrow acquire window. Once locked, it stays locked as long as the error stays inside a wider hold window. A drop out of lock has one of two effects, picked by a control input. It either sets a sticky loss flag, which software clears by reading status and then writing one to the flag, or it raises a one-cycle reset request. An interrupt request follows the sticky flag when interrupts are enabled.

If the oscillator stops, the handshake never completes. A comparison period that ends with a measurement still outstanding is therefore judged as a count of zero, so a dead oscillator still drops lock.

Top module: `fll_lock_detector`

## Requirements
- R1: Each judged period produces a one-cycle `dn_valid` pulse. In the same cycle `dn` holds the signed error, equal to the oscillator edge count over that period minus `mfd`.
- R2: A comparison period lasts exactly `period_len` reference cycles (`period_len` of 1 or more). With the oscillator stopped, consecutive `dn_valid` pulses are exactly `period_len` cycles apart.
- R3: While unlocked, `locked` rises when a judged error lies within [`acq_lo`, `acq_hi`], inclusive at both ends.
- R4: While locked, `locked` stays high while the error lies within [`hold_lo`, `hold_hi`] and falls when it leaves. An error that is inside the hold window but outside the acquire window keeps an existing lock and never creates a new one.
- R5: With `rst_on_loss` at 0, a loss of lock sets `lol_flag`. The flag stays set until it is cleared by the sequence in R6 or by `rst`.
- R6: `lol_flag` clears only when a `flag_clr_wr` pulse comes after a `status_rd` pulse given while the flag was set. A `flag_clr_wr` with no such earlier read leaves the flag set.
- R7: `irq` is high one cycle after the flag's update exactly when `lol_flag` is set and `irq_en` is 1.
- R8: With `rst_on_loss` at 1, a loss of lock gives a single one-cycle `reset_req` pulse and does not set `lol_flag`.
- R9: With `enable` at 0, `locked` is 0 from the next cycle on. After `enable` rises, the first period's measurement is discarded and produces no `dn_valid`.
- R10: If a period ends while the previous measurement is still outstanding, that period is judged with a count of zero, so `dn` equals the negative of `mfd`.
- R11: During and right after reset, `locked`, `lol_flag`, `irq`, `reset_req` and `dn_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; defines the comparison period |
| rst | input | 1 | Synchronous active-high reset, reference domain (also synchronized into the oscillator domain) |
| osc_clk | input | 1 | Oscillator clock under measurement |
| enable | input | 1 | Loop enable; low clears lock |
| period_len | input | PER_W | Comparison period length in reference cycles |
| mfd | input | CNT_W | Expected oscillator edge count per period |
| acq_lo | input | CNT_W+1 | Acquire window minimum (signed) |
| acq_hi | input | CNT_W+1 | Acquire window maximum (signed) |
| hold_lo | input | CNT_W+1 | Hold window minimum (signed) |
| hold_hi | input | CNT_W+1 | Hold window maximum (signed) |
| irq_en | input | 1 | Interrupt enable |
| rst_on_loss | input | 1 | 1: loss of lock requests reset instead of setting the flag |
| status_rd | input | 1 | Pulse: status read |
| flag_clr_wr | input | 1 | Pulse: write one to the loss flag |
| dn | output | CNT_W+1 | Signed count error of the last judged period |
| dn_valid | output | 1 | One-cycle pulse when `dn` is updated |
| locked | output | 1 | Lock status |
| lol_flag | output | 1 | Sticky loss-of-lock flag |
| irq | output | 1 | Interrupt request |
| reset_req | output | 1 | One-cycle reset request on loss of lock |

## Verification
The bench checks the asymmetry between the two windows by holding an error that lies between the acquire and hold limits, both from a locked state and from an unlocked one. A design with a single window would either drop lock or gain it there. It gives an unarmed write to the flag, which a design with no read-before-write ordering would obey. It stops the oscillator, which leaves a design with no timeout locked forever and lets the bench measure the exact period length from the timed-out evaluations. It also re-enables the loop and confirms that the first, partial period is never judged.

// File: rtl/fll_lock_pkg.sv
`timescale 1ns/1ps
package fll_lock_pkg;
  // Inclusive window test on sign-extended operands.
  function automatic logic in_win(input logic signed [31:0] v,
                                  input logic signed [31:0] lo,
                                  input logic signed [31:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/fll_sync.sv
`timescale 1ns/1ps
module fll_sync #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [N-1:0] st;
  always_ff @(posedge clk) st <= {st[N-2:0], d};
  assign q = st[N-1];
endmodule

// File: rtl/fll_osc_count.sv
`timescale 1ns/1ps
module fll_osc_count #(
  parameter int CNT_W  = 12,
  parameter int SYNC_N = 2
) (
  input  logic             osc_clk,
  input  logic             rst_async,
  input  logic             req_tgl,
  output logic [CNT_W-1:0] snap,
  output logic             ack_tgl
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             rst_o, req_s, req_d;
  logic [CNT_W-1:0] cnt;

  fll_sync #(.N(SYNC_N)) u_rst_sync (.clk(osc_clk), .d(rst_async), .q(rst_o));
  fll_sync #(.N(SYNC_N)) u_req_sync (.clk(osc_clk), .d(req_tgl),   .q(req_s));

  // Edge counter saturates; a request toggle snapshots it and restarts it,
  // the capturing edge being the first edge of the new period.
  always_ff @(posedge osc_clk) begin
    if (rst_o) begin
      cnt     <= '0;
      snap    <= '0;
      ack_tgl <= 1'b0;
      req_d   <= 1'b0;
    end else begin
      req_d <= req_s;
      if (req_s != req_d) begin
        snap    <= cnt;
        cnt     <= CNT_W'(1);
        ack_tgl <= ~ack_tgl;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fll_lock_fsm.sv
`timescale 1ns/1ps
module fll_lock_fsm
  import fll_lock_pkg::*;
#(
  parameter int CNT_W = 12,
  localparam int ERR_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    go,
  input  logic [CNT_W-1:0]        count,
  input  logic [CNT_W-1:0]        mfd,
  input  logic signed [ERR_W-1:0] acq_lo,
  input  logic signed [ERR_W-1:0] acq_hi,
  input  logic signed [ERR_W-1:0] hold_lo,
  input  logic signed [ERR_W-1:0] hold_hi,
  output logic signed [ERR_W-1:0] dn,
  output logic                    dn_valid,
  output logic                    locked,
  output logic                    loss
);
  logic signed [ERR_W-1:0] dn_c;
  logic                    in_acq, in_hold;

  assign dn_c    = $signed({1'b0, count}) - $signed({1'b0, mfd});
  assign in_acq  = in_win(32'(dn_c), 32'(acq_lo), 32'(acq_hi));
  assign in_hold = in_win(32'(dn_c), 32'(hold_lo), 32'(hold_hi));

  always_ff @(posedge clk) begin
    if (rst) begin
      dn       <= '0;
      dn_valid <= 1'b0;
      locked   <= 1'b0;
      loss     <= 1'b0;
    end else begin
      dn_valid <= go;
      loss     <= 1'b0;
      if (go) dn <= dn_c;
      if (!enable) begin
        locked <= 1'b0;
      end else if (go) begin
        if (!locked && in_acq) begin
          locked <= 1'b1;
        end else if (locked && !in_hold) begin
          locked <= 1'b0;
          loss   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fll_lock_detector.sv
`timescale 1ns/1ps
module fll_lock_detector #(
  parameter int CNT_W  = 12,
  parameter int PER_W  = 10,
  parameter int SYNC_N = 2,
  localparam int ERR_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    osc_clk,
  input  logic                    enable,
  input  logic [PER_W-1:0]        period_len,
  input  logic [CNT_W-1:0]        mfd,
  input  logic signed [ERR_W-1:0] acq_lo,
  input  logic signed [ERR_W-1:0] acq_hi,
  input  logic signed [ERR_W-1:0] hold_lo,
  input  logic signed [ERR_W-1:0] hold_hi,
  input  logic                    irq_en,
  input  logic                    rst_on_loss,
  input  logic                    status_rd,
  input  logic                    flag_clr_wr,
  output logic signed [ERR_W-1:0] dn,
  output logic                    dn_valid,
  output logic                    locked,
  output logic                    lol_flag,
  output logic                    irq,
  output logic                    reset_req
);
  logic [PER_W-1:0] tmr;
  logic             period_end, issue, timeout;
  logic             req_tgl, ack_tgl, ack_s, ack_d, ack_edge;
  logic             pending, stale, skip;
  logic [CNT_W-1:0] snap, ev_count;
  logic             ev_valid, go, loss;
  logic             armed, clr_hit, flag_d;

  // Oscillator-domain counter and toggle handshake.
  fll_osc_count #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_osc (
    .osc_clk(osc_clk), .rst_async(rst), .req_tgl(req_tgl),
    .snap(snap), .ack_tgl(ack_tgl)
  );
  fll_sync #(.N(SYNC_N)) u_ack_sync (.clk(clk), .d(ack_tgl), .q(ack_s));

  assign period_end = enable && (tmr == period_len - 1'b1);
  assign ack_edge   = ack_s ^ ack_d;
  assign issue      = period_end && (!pending || ack_edge);
  assign timeout    = period_end && pending && !ack_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= '0;
      req_tgl <= 1'b0;
      ack_d   <= 1'b0;
      pending <= 1'b0;
      stale   <= 1'b0;
      skip    <= 1'b1;
    end else begin
      ack_d <= ack_s;
      tmr   <= (!enable || period_end) ? '0 : tmr + 1'b1;
      if (issue) begin
        req_tgl <= ~req_tgl;
        pending <= 1'b1;
        stale   <= 1'b0;
      end else begin
        if (ack_edge) pending <= 1'b0;
        if (timeout)  stale   <= 1'b1;
      end
      if (!enable)       skip <= 1'b1;
      else if (ev_valid) skip <= 1'b0;
    end
  end

  // A late measurement is judged as zero; a stale acknowledge is dropped.
  always_comb begin
    ev_valid = 1'b0;
    ev_count = snap;
    if (ack_edge && !stale) begin
      ev_valid = 1'b1;
    end else if (timeout) begin
      ev_valid = 1'b1;
      ev_count = '0;
    end
  end
  assign go = ev_valid && enable && !skip;

  fll_lock_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .go(go), .count(ev_count),
    .mfd(mfd), .acq_lo(acq_lo), .acq_hi(acq_hi), .hold_lo(hold_lo),
    .hold_hi(hold_hi), .dn(dn), .dn_valid(dn_valid), .locked(locked),
    .loss(loss)
  );

  // Sticky flag with read-then-write clear.
  assign clr_hit = flag_clr_wr && armed;
  always_comb begin
    flag_d = lol_flag;
    if (clr_hit) flag_d = 1'b0;
    if (loss && !rst_on_loss) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lol_flag  <= 1'b0;
      irq       <= 1'b0;
      reset_req <= 1'b0;
      armed     <= 1'b0;
    end else begin
      lol_flag  <= flag_d;
      irq       <= flag_d && irq_en;
      reset_req <= loss && rst_on_loss;
      if (flag_clr_wr)                armed <= 1'b0;
      else if (status_rd && lol_flag) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/fll_lock_checker.sv
`timescale 1ns/1ps
module fll_lock_checker #(
  parameter int ERR_W = 13
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enable,
  input logic                    irq_en,
  input logic                    rst_on_loss,
  input logic                    flag_clr_wr,
  input logic signed [ERR_W-1:0] acq_lo,
  input logic signed [ERR_W-1:0] acq_hi,
  input logic signed [ERR_W-1:0] hold_lo,
  input logic signed [ERR_W-1:0] hold_hi,
  input logic signed [ERR_W-1:0] dn,
  input logic                    locked,
  input logic                    lol_flag,
  input logic                    irq,
  input logic                    reset_req
);
  p_gain_in_acq_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (dn >= $past(acq_lo)) && (dn <= $past(acq_hi)));

  p_drop_out_of_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(locked) && $past(enable)) |-> ((dn < $past(hold_lo)) || (dn > $past(hold_hi))));

  p_clear_needs_write_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(lol_flag) |-> $past(flag_clr_wr));

  p_irq_follows_flag_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (lol_flag && $past(irq_en)));

  p_no_flag_in_reset_mode_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(lol_flag) |-> !$past(rst_on_loss));

  p_reset_req_single_r8: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  p_disable_unlocks_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !locked);
endmodule

bind fll_lock_detector fll_lock_checker #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .irq_en(irq_en),
  .rst_on_loss(rst_on_loss), .flag_clr_wr(flag_clr_wr),
  .acq_lo(acq_lo), .acq_hi(acq_hi), .hold_lo(hold_lo), .hold_hi(hold_hi),
  .dn(dn), .locked(locked), .lol_flag(lol_flag), .irq(irq),
  .reset_req(reset_req)
);

// File: tb/fll_lock_detector_tb.sv
`timescale 1ns/1ps
module fll_lock_detector_tb;
  localparam int CNT_W = 12;
  localparam int PER_W = 10;
  localparam int ERR_W = CNT_W + 1;
  localparam int NV    = 9;

  // Table: oscillator half period (ps), dn range, expected lock and flag.
  // Period 100 ref cycles (2000 ns), mfd 1000, acquire [-4,4], hold [-20,20].
  localparam int VH  [NV] = '{1000,  993, 1000,  970,  993, 1000, 1010, 1040, 1000};
  localparam int VLO [NV] = '{  -1,    6,   -1,   30,    6,   -1,  -11,  -39,   -1};
  localparam int VHI [NV] = '{   1,    8,    1,   32,    8,    1,   -9,  -37,    1};
  localparam int VLK [NV] = '{   1,    1,    1,    0,    0,    1,    1,    0,    1};
  localparam int VFL [NV] = '{   0,    0,    0,    1,    1,    1,    1,    1,    1};

  logic clk = 0, osc_clk = 0, osc_run = 1;
  int   osc_half_ps = 1000;
  logic rst = 1, enable = 0, irq_en = 1, rst_on_loss = 0;
  logic status_rd = 0, flag_clr_wr = 0;
  logic [PER_W-1:0] period_len = 10'd100;
  logic [CNT_W-1:0] mfd = 12'd1000;
  logic signed [ERR_W-1:0] acq_lo = -13'sd4, acq_hi = 13'sd4;
  logic signed [ERR_W-1:0] hold_lo = -13'sd20, hold_hi = 13'sd20;
  logic signed [ERR_W-1:0] dn;
  logic dn_valid, locked, lol_flag, irq, reset_req;

  int n_chk = 0, n_err = 0, cyc = 0, rr_cnt = 0, dv_cnt = 0;

  always #10 clk = ~clk;
  always begin
    #(osc_half_ps * 1ps);
    if (osc_run) osc_clk = ~osc_clk;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (reset_req) rr_cnt <= rr_cnt + 1;
    if (dn_valid)  dv_cnt <= dv_cnt + 1;
  end

  fll_lock_detector #(.CNT_W(CNT_W), .PER_W(PER_W)) u_dut (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .enable(enable),
    .period_len(period_len), .mfd(mfd), .acq_lo(acq_lo), .acq_hi(acq_hi),
    .hold_lo(hold_lo), .hold_hi(hold_hi), .irq_en(irq_en),
    .rst_on_loss(rst_on_loss), .status_rd(status_rd),
    .flag_clr_wr(flag_clr_wr), .dn(dn), .dn_valid(dn_valid),
    .locked(locked), .lol_flag(lol_flag), .irq(irq), .reset_req(reset_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_eval();
    do @(negedge clk); while (!dn_valid);
  endtask

  task automatic pulse_rd();
    status_rd = 1; @(negedge clk); status_rd = 0; @(negedge clk);
  endtask

  task automatic pulse_wr();
    flag_clr_wr = 1; @(negedge clk); flag_clr_wr = 0; repeat (2) @(negedge clk);
  endtask

  task automatic settle(input int half);
    osc_half_ps = half;
    wait_eval();
    wait_eval();
  endtask

  initial begin
    int t0;
    repeat (5) @(negedge clk);
    // R11: reset state
    check("R11 locked", locked, 0);
    check("R11 lol_flag", lol_flag, 0);
    check("R11 irq", irq, 0);
    check("R11 reset_req", reset_req, 0);
    check("R11 dn_valid", dn_valid, 0);
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11 locked after release", locked, 0);
    enable = 1;

    // Table walk: R1 dn, R3/R4 lock decisions, R5 sticky flag, R7 irq.
    for (int i = 0; i < NV; i++) begin
      settle(VH[i]);
      check_rng($sformatf("R1 dn vec%0d", i), int'(dn), VLO[i], VHI[i]);
      check($sformatf("R3_R4 locked vec%0d", i), locked, VLK[i]);
      repeat (2) @(negedge clk);
      check($sformatf("R5 flag vec%0d", i), lol_flag, VFL[i]);
      check($sformatf("R7 irq vec%0d", i), irq, VFL[i]);
    end

    // R6: write without a preceding read does nothing.
    pulse_wr();
    check("R6 unarmed write keeps flag", lol_flag, 1);
    // R6: read then write clears.
    pulse_rd();
    check("R6 flag still set after read", lol_flag, 1);
    pulse_wr();
    check("R6 read-then-write clears", lol_flag, 0);
    check("R7 irq drops with flag", irq, 0);

    // R7: flag set with irq disabled.
    irq_en = 0;
    settle(1040);
    repeat (2) @(negedge clk);
    check("R7 loss with irq_en=0 sets flag (R5)", lol_flag, 1);
    check("R7 irq masked", irq, 0);
    irq_en = 1;
    repeat (2) @(negedge clk);
    check("R7 irq on enable", irq, 1);
    pulse_rd();
    pulse_wr();
    check("R6 cleared again", lol_flag, 0);

    // R8: reset-request mode.
    settle(1000);
    check("R8 relocked", locked, 1);
    rst_on_loss = 1;
    rr_cnt = 0;
    settle(1040);
    repeat (3) @(negedge clk);
    check("R8 one reset_req pulse", rr_cnt, 1);
    check("R8 flag not set", lol_flag, 0);
    check("R8 unlocked", locked, 0);
    rst_on_loss = 0;

    // R9: disable clears lock; first period after enable discarded.
    settle(1000);
    check("R9 locked before disable", locked, 1);
    enable = 0;
    repeat (2) @(negedge clk);
    check("R9 disable clears lock", locked, 0);
    repeat (3) @(negedge clk);
    dv_cnt = 0;
    enable = 1;
    repeat (180) @(negedge clk);
    check("R9 first period discarded", dv_cnt, 0);
    wait_eval();
    check("R9 relock after enable", locked, 1);

    // R10: stopped oscillator is judged as zero count; R2 exact period.
    osc_run = 0;
    wait_eval();
    check("R10 dn equals -mfd", int'(dn), -1000);
    check("R10 stopped osc drops lock", locked, 0);
    t0 = cyc;
    wait_eval();
    check("R2 period length", cyc - t0, 100);
    repeat (2) @(negedge clk);
    check("R5 flag after stop", lol_flag, 1);

    // R5: reset clears the sticky flag.
    osc_run = 1;
    rst = 1;
    repeat (6) @(negedge clk);
    check("R5 reset clears flag", lol_flag, 0);
    rst = 0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule